// File: doc/BRIEF.md
# Triangle to Tile Binner

The binner takes in every screen-space triangle of one frame before any pixel is drawn. Each triangle's integer bounding box is clamped to the screen. The tiles of 32 by 16 pixels that the clamped box overlaps are worked out, and the triangle's sequence number is appended to an on-chip list for each of those tiles. Triangles arrive on a valid/ready stream. A flag on the stream marks the final triangle of the frame.

When the frame's final triangle has been sorted, the block replays the lists. It walks the tiles in raster order and hands each one to a downstream tile renderer on a second valid/ready stream. Each tile is sent as a start marker that carries the tile coordinates, then the tile's triangle numbers, then an end marker. When the last tile has been sent, the lists are emptied and the block accepts the next frame. The screen size, list depth, coordinate width and index width are parameters.

Top module: `tile_binner`

## Requirements
- R1: Binning and replay never overlap. `in_ready` is high only while the block is idle in binning, and it falls for at least one cycle after each accepted triangle whose clamped box is on screen. It also falls after the frame's final triangle. `out_valid` stays low until the final triangle of the frame has been accepted and sorted.
- R2: Tile column is x>>5 and tile row is y>>4. A triangle is listed in exactly the tiles overlapped by its bounding box after clamping to [0, SCR_W-1] x [0, SCR_H-1].
- R3: A triangle whose bounding box lies wholly off screen appears in no list. It still uses up its sequence number.
- R4: Each tile list holds at most LIST_DEPTH entries. An entry that arrives for a full tile is dropped and sets `overflow`. `overflow` stays high until reset.
- R5: Replay visits every tile, empty ones included. Tiles go left to right within a row, and rows go from top to bottom. Each tile gives a start item (`out_kind`=0), its triangle items (`out_kind`=1), then an end item (`out_kind`=2). `out_col` and `out_row` carry the tile coordinates, and `out_idx` is 0 on markers.
- R6: A triangle's index is the number of triangles accepted before it in the frame, counting from 0. Within one tile the indices come out in submission order.
- R7: After a frame has been replayed, all lists are empty and indices start again at 0.
- R8: After reset, `in_ready`=1, `out_valid`=0 and `overflow`=0.
- R9: While `out_valid` is high and `out_ready` is low, all output fields hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Triangle offered |
| in_ready | output | 1 | Triangle accepted when high with in_valid |
| in_last | input | 1 | Offered triangle ends the frame |
| in_x0 | input | CW | Vertex 0 x, signed |
| in_y0 | input | CW | Vertex 0 y, signed |
| in_x1 | input | CW | Vertex 1 x, signed |
| in_y1 | input | CW | Vertex 1 y, signed |
| in_x2 | input | CW | Vertex 2 x, signed |
| in_y2 | input | CW | Vertex 2 y, signed |
| out_valid | output | 1 | Replay item present |
| out_ready | input | 1 | Downstream takes the item |
| out_kind | output | 2 | 0 start, 1 triangle, 2 end |
| out_col | output | COL_W | Tile column |
| out_row | output | ROW_W | Tile row |
| out_idx | output | IDX_W | Triangle index, 0 on markers |
| overflow | output | 1 | Sticky list-full flag |

## Verification
The case that is hardest to reach from the ports is a full tile list combined with the sticky flag. The stimulus sends six triangles into one corner tile of a frame whose list depth is four. It then checks that only the first four indices are replayed for that tile and that `overflow` stays high through a later, empty frame. Clamping is reached with triangles that hang off each screen edge and with a triangle far larger than the screen. Tile borders are reached with vertices at x=31/32 and y=15/16. A randomly stalling `out_ready` holds replay items in place, so their stability can be checked.

// File: rtl/tile_binner_pkg.sv
package tile_binner_pkg;
  localparam int TILE_XS = 5;   // 32-pixel tile width
  localparam int TILE_YS = 4;   // 16-pixel tile height

  typedef enum logic [1:0] {
    MK_START = 2'd0,
    MK_TRI   = 2'd1,
    MK_END   = 2'd2
  } mark_t;

  function automatic int min3(int a, int b, int c);
    int m;
    m = (a < b) ? a : b;
    return (m < c) ? m : c;
  endfunction

  function automatic int max3(int a, int b, int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  function automatic int clampi(int v, int lo, int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction
endpackage

// File: rtl/tbin_bbox.sv
module tbin_bbox
  import tile_binner_pkg::*;
#(
  parameter int CW    = 12,
  parameter int SCR_W = 128,
  parameter int SCR_H = 64,
  parameter int COL_W = 2,
  parameter int ROW_W = 2
) (
  input  logic signed [CW-1:0] x0,
  input  logic signed [CW-1:0] y0,
  input  logic signed [CW-1:0] x1,
  input  logic signed [CW-1:0] y1,
  input  logic signed [CW-1:0] x2,
  input  logic signed [CW-1:0] y2,
  output logic                 onscreen,
  output logic [COL_W-1:0]     c_lo,
  output logic [COL_W-1:0]     c_hi,
  output logic [ROW_W-1:0]     r_lo,
  output logic [ROW_W-1:0]     r_hi
);
  int xmin, xmax, ymin, ymax;

  always_comb begin
    xmin = min3(int'(x0), int'(x1), int'(x2));
    xmax = max3(int'(x0), int'(x1), int'(x2));
    ymin = min3(int'(y0), int'(y1), int'(y2));
    ymax = max3(int'(y0), int'(y1), int'(y2));
    onscreen = (xmax >= 0) && (xmin < SCR_W) && (ymax >= 0) && (ymin < SCR_H);
    c_lo = COL_W'(clampi(xmin, 0, SCR_W-1) >>> TILE_XS);
    c_hi = COL_W'(clampi(xmax, 0, SCR_W-1) >>> TILE_XS);
    r_lo = ROW_W'(clampi(ymin, 0, SCR_H-1) >>> TILE_YS);
    r_hi = ROW_W'(clampi(ymax, 0, SCR_H-1) >>> TILE_YS);
  end
endmodule

// File: rtl/tbin_list_store.sv
module tbin_list_store #(
  parameter int NT    = 16,
  parameter int DEPTH = 4,
  parameter int IDX_W = 8,
  parameter int TW    = 4,
  parameter int CNT_W = 3,
  parameter int PW    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [TW-1:0]    wr_tile,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TW-1:0]    rd_tile,
  input  logic [PW-1:0]    rd_pos,
  output logic [CNT_W-1:0] rd_count,
  output logic [IDX_W-1:0] rd_idx,
  output logic             overflow
);
  logic [CNT_W-1:0] cnt [NT];
  logic [IDX_W-1:0] mem [NT][DEPTH];
  logic             full_hit;

  assign full_hit = wr_en && (cnt[wr_tile] == CNT_W'(DEPTH));
  assign rd_count = cnt[rd_tile];
  assign rd_idx   = mem[rd_tile][rd_pos];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int t = 0; t < NT; t++) cnt[t] <= '0;
      overflow <= 1'b0;
    end else if (clr) begin
      for (int t = 0; t < NT; t++) cnt[t] <= '0;
    end else if (wr_en) begin
      if (full_hit) overflow <= 1'b1;
      else          cnt[wr_tile] <= cnt[wr_tile] + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !full_hit && !clr) mem[wr_tile][PW'(cnt[wr_tile])] <= wr_idx;
  end

  // R4: a full list turns an append into an overflow
  assert_full_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (full_hit && !clr) |=> overflow);
  // R4: the flag never clears without reset
  assert_no_overflow_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(overflow));
  // R7: clearing and appending never coincide
  assert_no_clr_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(clr && wr_en));
endmodule

// File: rtl/tbin_replay.sv
module tbin_replay
  import tile_binner_pkg::*;
#(
  parameter int NT    = 16,
  parameter int COLS  = 4,
  parameter int COL_W = 2,
  parameter int ROW_W = 2,
  parameter int TW    = 4,
  parameter int CNT_W = 3,
  parameter int PW    = 2,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] rd_count,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TW-1:0]    rd_tile,
  output logic [PW-1:0]    rd_pos,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [1:0]       out_kind,
  output logic [COL_W-1:0] out_col,
  output logic [ROW_W-1:0] out_row,
  output logic [IDX_W-1:0] out_idx,
  output logic             done
);
  typedef enum logic [1:0] {P_IDLE, P_START, P_TRI, P_END} phase_t;
  phase_t           phase;
  logic [TW-1:0]    tile;
  logic [PW-1:0]    pos;
  logic [COL_W-1:0] col;
  logic [ROW_W-1:0] row;
  logic             xfer, last_pos;

  assign xfer     = out_valid && out_ready;
  assign last_pos = (CNT_W'(pos) + CNT_W'(1)) == rd_count;
  assign done     = xfer && (phase == P_END) && (tile == TW'(NT-1));

  always_comb begin
    out_valid = (phase != P_IDLE);
    out_col   = col;
    out_row   = row;
    out_idx   = (phase == P_TRI) ? rd_idx : '0;
    rd_tile   = tile;
    rd_pos    = pos;
    case (phase)
      P_TRI:   out_kind = MK_TRI;
      P_END:   out_kind = MK_END;
      default: out_kind = MK_START;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= P_IDLE;
      tile  <= '0;
      pos   <= '0;
      col   <= '0;
      row   <= '0;
    end else begin
      case (phase)
        P_IDLE: if (start) phase <= P_START;
        P_START: if (xfer) begin
          pos   <= '0;
          phase <= (rd_count == '0) ? P_END : P_TRI;
        end
        P_TRI: if (xfer) begin
          if (last_pos) phase <= P_END;
          else          pos   <= pos + PW'(1);
        end
        P_END: if (xfer) begin
          if (tile == TW'(NT-1)) begin
            phase <= P_IDLE;
            tile  <= '0;
            col   <= '0;
            row   <= '0;
          end else begin
            phase <= P_START;
            tile  <= tile + TW'(1);
            if (col == COL_W'(COLS-1)) begin
              col <= '0;
              row <= row + ROW_W'(1);
            end else begin
              col <= col + COL_W'(1);
            end
          end
        end
        default: phase <= P_IDLE;
      endcase
    end
  end

  // R9: a stalled item holds every field
  assert_hold_on_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_kind) && $stable(out_col)
                                   && $stable(out_row) && $stable(out_idx)));
  // R5: the tile walk stays inside the grid
  assert_tile_in_grid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(tile) < NT);
  // R5: each end marker is followed by a start marker or by idle
  assert_end_then_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && phase == P_END) |=> (phase == P_START || phase == P_IDLE));
endmodule

// File: rtl/tile_binner.sv
module tile_binner
  import tile_binner_pkg::*;
#(
  parameter int SCR_W      = 128,
  parameter int SCR_H      = 64,
  parameter int CW         = 12,
  parameter int IDX_W      = 8,
  parameter int LIST_DEPTH = 4,
  localparam int COLS  = (SCR_W + (1 << TILE_XS) - 1) >> TILE_XS,
  localparam int ROWS  = (SCR_H + (1 << TILE_YS) - 1) >> TILE_YS,
  localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic                 in_last,
  input  logic signed [CW-1:0] in_x0,
  input  logic signed [CW-1:0] in_y0,
  input  logic signed [CW-1:0] in_x1,
  input  logic signed [CW-1:0] in_y1,
  input  logic signed [CW-1:0] in_x2,
  input  logic signed [CW-1:0] in_y2,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [1:0]           out_kind,
  output logic [COL_W-1:0]     out_col,
  output logic [ROW_W-1:0]     out_row,
  output logic [IDX_W-1:0]     out_idx,
  output logic                 overflow
);
  localparam int NT    = COLS * ROWS;
  localparam int TW    = (NT > 1) ? $clog2(NT) : 1;
  localparam int CNT_W = $clog2(LIST_DEPTH + 1);
  localparam int PW    = (LIST_DEPTH > 1) ? $clog2(LIST_DEPTH) : 1;

  typedef enum logic [1:0] {S_BIN, S_WALK, S_REPLAY} state_t;
  state_t state;

  logic             acc, onscreen, walk_end, replay_go, replay_done, wr_en;
  logic [COL_W-1:0] b_clo, b_chi, c_cur, c_lo, c_hi;
  logic [ROW_W-1:0] b_rlo, b_rhi, r_cur, r_hi;
  logic [IDX_W-1:0] next_idx, cur_idx;
  logic             last_q;
  logic [TW-1:0]    wr_tile, rd_tile;
  logic [PW-1:0]    rd_pos;
  logic [CNT_W-1:0] rd_count;
  logic [IDX_W-1:0] rd_idx;

  tbin_bbox #(.CW(CW), .SCR_W(SCR_W), .SCR_H(SCR_H), .COL_W(COL_W), .ROW_W(ROW_W)) u_bbox (
    .x0(in_x0), .y0(in_y0), .x1(in_x1), .y1(in_y1), .x2(in_x2), .y2(in_y2),
    .onscreen(onscreen), .c_lo(b_clo), .c_hi(b_chi), .r_lo(b_rlo), .r_hi(b_rhi));

  assign in_ready  = (state == S_BIN);
  assign acc       = in_valid && in_ready;
  assign wr_en     = (state == S_WALK);
  assign wr_tile   = TW'(int'(r_cur) * COLS + int'(c_cur));
  assign walk_end  = wr_en && (c_cur == c_hi) && (r_cur == r_hi);
  assign replay_go = (acc && !onscreen && in_last) || (walk_end && last_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_BIN;
      next_idx <= '0;
      cur_idx  <= '0;
      last_q   <= 1'b0;
      c_cur    <= '0;
      c_lo     <= '0;
      c_hi     <= '0;
      r_cur    <= '0;
      r_hi     <= '0;
    end else begin
      case (state)
        S_BIN: if (acc) begin
          cur_idx  <= next_idx;
          next_idx <= next_idx + IDX_W'(1);
          last_q   <= in_last;
          c_cur    <= b_clo;
          c_lo     <= b_clo;
          c_hi     <= b_chi;
          r_cur    <= b_rlo;
          r_hi     <= b_rhi;
          if (onscreen)    state <= S_WALK;
          else if (in_last) state <= S_REPLAY;
        end
        S_WALK: begin
          if (walk_end) begin
            state <= last_q ? S_REPLAY : S_BIN;
          end else if (c_cur == c_hi) begin
            c_cur <= c_lo;
            r_cur <= r_cur + ROW_W'(1);
          end else begin
            c_cur <= c_cur + COL_W'(1);
          end
        end
        S_REPLAY: if (replay_done) begin
          state    <= S_BIN;
          next_idx <= '0;
        end
        default: state <= S_BIN;
      endcase
    end
  end

  tbin_list_store #(.NT(NT), .DEPTH(LIST_DEPTH), .IDX_W(IDX_W), .TW(TW), .CNT_W(CNT_W), .PW(PW))
  u_store (
    .clk(clk), .rst_n(rst_n), .clr(replay_done), .wr_en(wr_en), .wr_tile(wr_tile),
    .wr_idx(cur_idx), .rd_tile(rd_tile), .rd_pos(rd_pos), .rd_count(rd_count),
    .rd_idx(rd_idx), .overflow(overflow));

  tbin_replay #(.NT(NT), .COLS(COLS), .COL_W(COL_W), .ROW_W(ROW_W), .TW(TW), .CNT_W(CNT_W),
                .PW(PW), .IDX_W(IDX_W)) u_replay (
    .clk(clk), .rst_n(rst_n), .start(replay_go), .rd_count(rd_count), .rd_idx(rd_idx),
    .rd_tile(rd_tile), .rd_pos(rd_pos), .out_ready(out_ready), .out_valid(out_valid),
    .out_kind(out_kind), .out_col(out_col), .out_row(out_row), .out_idx(out_idx),
    .done(replay_done));

  // R1: accepting input and replaying never happen together
  assert_no_mix_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !out_valid);
  // R3: an off-screen triangle causes no list write
  assert_offscreen_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !onscreen) |=> !wr_en);
  // R7: replay completion returns to binning
  assert_back_to_bin_R7: assert property (@(posedge clk) disable iff (!rst_n)
    replay_done |=> in_ready);
endmodule

// File: tb/tile_binner_bench.sv
module tile_binner_bench;
  localparam int SCR_W = 128, SCR_H = 64, CW = 12, IDX_W = 8, DEPTH = 4;
  localparam int COLS = 4, ROWS = 4, NT = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b0;
  logic signed [CW-1:0] in_x0 = '0, in_y0 = '0, in_x1 = '0, in_y1 = '0, in_x2 = '0, in_y2 = '0;
  logic in_ready, out_valid, overflow;
  logic [1:0] out_kind;
  logic [1:0] out_col, out_row;
  logic [IDX_W-1:0] out_idx;

  always #2.5 clk = ~clk;   // 200 MHz

  tile_binner #(.SCR_W(SCR_W), .SCR_H(SCR_H), .CW(CW), .IDX_W(IDX_W), .LIST_DEPTH(DEPTH))
  u_tile_binner (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_last(in_last),
    .in_x0(in_x0), .in_y0(in_y0), .in_x1(in_x1), .in_y1(in_y1), .in_x2(in_x2), .in_y2(in_y2),
    .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind), .out_col(out_col),
    .out_row(out_row), .out_idx(out_idx), .overflow(overflow));

  int checks = 0, errors = 0;
  int exp_q[$];
  int lists[NT][$];
  int model_idx = 0;
  logic ovf_model = 1'b0;
  logic stall_seen = 1'b0;
  int stall_val = 0;
  logic stall_rdy = 1'b0;

  function automatic int pack(int k, int c, int r, int i);
    return (k << 24) | (c << 16) | (r << 8) | i;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // reference: bounding box, clamp, tile range, per-tile lists
  task automatic send(int x0, int y0, int x1, int y1, int x2, int y2, bit last);
    int lx, hx, ly, hy;
    bit on;
    lx = (x0 < x1 ? (x0 < x2 ? x0 : x2) : (x1 < x2 ? x1 : x2));
    hx = (x0 > x1 ? (x0 > x2 ? x0 : x2) : (x1 > x2 ? x1 : x2));
    ly = (y0 < y1 ? (y0 < y2 ? y0 : y2) : (y1 < y2 ? y1 : y2));
    hy = (y0 > y1 ? (y0 > y2 ? y0 : y2) : (y1 > y2 ? y1 : y2));
    on = !(hx < 0 || lx >= SCR_W || hy < 0 || ly >= SCR_H);
    if (on) begin
      lx = (lx < 0) ? 0 : lx;  hx = (hx > SCR_W-1) ? SCR_W-1 : hx;
      ly = (ly < 0) ? 0 : ly;  hy = (hy > SCR_H-1) ? SCR_H-1 : hy;
      for (int r = ly / 16; r <= hy / 16; r++)
        for (int c = lx / 32; c <= hx / 32; c++)
          if (lists[r*COLS+c].size() < DEPTH) lists[r*COLS+c].push_back(model_idx);
          else ovf_model = 1'b1;
    end
    model_idx++;
    if (last) begin
      for (int t = 0; t < NT; t++) begin
        exp_q.push_back(pack(0, t % COLS, t / COLS, 0));
        foreach (lists[t][k]) exp_q.push_back(pack(1, t % COLS, t / COLS, lists[t][k]));
        exp_q.push_back(pack(2, t % COLS, t / COLS, 0));
        lists[t].delete();
      end
      model_idx = 0;
    end
    in_x0 = CW'(x0); in_y0 = CW'(y0); in_x1 = CW'(x1);
    in_y1 = CW'(y1); in_x2 = CW'(x2); in_y2 = CW'(y2);
    in_last = last; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    check("R1 in_ready after accept", int'(in_ready), (on || last) ? 0 : 1);
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || out_valid) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // backpressure pattern for replay
  always @(posedge clk) #1 out_ready <= ($urandom % 4) != 0;

  // monitor: compare every replayed item with the scoreboard head
  always @(negedge clk) if (rst_n) begin
    if (stall_seen && out_valid)
      check("R9 held while stalled", pack(out_kind, out_col, out_row, out_idx), stall_val);
    stall_seen = out_valid && !out_ready;
    stall_val  = pack(out_kind, out_col, out_row, out_idx);
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check("R1 output before frame end", 1, 0);
      end else begin
        check("R2 R5 R6 replay item", pack(out_kind, out_col, out_row, out_idx),
              exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 in_ready at reset", int'(in_ready), 1);
    check("R8 out_valid at reset", int'(out_valid), 0);
    check("R8 overflow at reset", int'(overflow), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // frame 1: single tile, span, off screen, clamps, tile borders, giant
    send(2, 2, 10, 3, 5, 12, 0);
    send(40, 5, 70, 20, 50, 10, 0);
    send(-20, -5, -3, -1, -10, -8, 0);          // R3
    send(-10, 50, 40, 70, 5, 60, 0);            // R2 clamp
    send(31, 15, 31, 15, 31, 15, 0);            // R2 border low side
    send(32, 16, 32, 16, 32, 16, 0);            // R2 border high side
    send(200, 10, 300, 20, 250, 30, 0);         // R3 right of screen
    check("R1 no output during binning", int'(out_valid), 0);
    send(-100, -100, 500, -50, 100, 400, 1);
    drain();
    check("R4 overflow clear after frame 1", int'(overflow), int'(ovf_model));
    // frame 2: six triangles into tile (3,3) with depth 4; R6 indices restart (R7)
    for (int i = 0; i < 6; i++) send(100 + i, 50, 110, 55, 105, 60, 0);
    send(0, 0, 1, 1, 2, 2, 1);
    drain();
    check("R4 overflow set", int'(overflow), 1);
    // frame 3: only an off-screen triangle; all tiles empty, flag sticky (R7)
    send(-40, 70, -30, 80, -35, 90, 1);
    drain();
    check("R4 overflow sticky", int'(overflow), 1);
    check("R7 scoreboard empty", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule